// File: doc/BRIEF.md
# Edge/Level Configurable Interrupt Controller

This block collects up to 32 interrupt request lines into one processor interrupt. Each line is fixed at build time as either edge-sensitive or level-sensitive by a per-source kind parameter. Each line first passes a two-flop synchronizer. A request is then captured into a status register and filtered by a software enable mask, which gives a pending set. One output, `irq_o`, tells the processor that something pending needs service.

Software sees the block through a small word-addressed read/write port. It reads status, pending and a vector that names the lowest pending source. It writes the enable mask and a two-bit master control word. It clears serviced requests by writing ones to an acknowledge word. A level-sensitive line that is still held high is captured again from its live state on every cycle. An acknowledge therefore cannot drop it. An edge-sensitive line is captured only when it rises. Once acknowledged, it stays clear until the line rises again.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, status, pending, enable and master control all read 0, `irq_o` is 0, and the vector word reads all ones.
- R2: A level source (kind bit 0) with master bit 1 set and its synchronized line high has its status bit set. Acknowledging it while the line is still high leaves the bit set.
- R3: An edge source (kind bit 1) sets its status bit only when its synchronized line rises. After an acknowledge, the bit stays 0 while the line is held high.
- R4: While master bit 1 is 0, no input sets any status bit. A rise that happened while the bit was 0 is not captured when the bit is later set.
- R5: Writing the acknowledge word (byte offset 0xC) clears each status bit whose data bit is 1. Data bits of 0 leave status unchanged. An edge event in the same cycle as its acknowledge wins, and the bit stays set.
- R6: The pending word (byte offset 0x4) always reads status AND enable. Enable is at byte offset 0x8 and status at 0x0.
- R7: `irq_o` is 1 exactly when master bit 0 is set and at least one pending bit is 1. Master control is at byte offset 0x1C, bit 0 gates the output and bit 1 gates capture.
- R8: The vector word (byte offset 0x18) reads the index of the lowest-numbered pending source, or all ones when nothing is pending.
- R9: Writes to the status and pending words have no effect, and the acknowledge word reads as 0.
- R10: A line that rises between clock edges shows in status, and therefore in `irq_o`, only after the third following rising clock edge. Read data returns one cycle after the read request, with `bus_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | N_SRC | Asynchronous interrupt request lines |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
Level lines are held high across acknowledges to show that the status bit survives. Edge lines are held high across acknowledges to show that it does not. Lines are raised while capture is off and then left high when capture turns on, which separates a latched rise from a live level. Several enable masks over the same status pattern tell the pending AND, the output gate and the lowest-index vector apart. A rise placed in the same edge as its acknowledge, and a cycle-by-cycle watch of `irq_o` after a rise, pin down the ordering rule and the synchronizer latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Word index (byte address bits [4:2]) of each register.
    typedef enum logic [2:0] {
        W_STATUS = 3'd0,
        W_PEND   = 3'd1,
        W_ENABLE = 3'd2,
        W_ACK    = 3'd3,
        W_RSVD4  = 3'd4,
        W_RSVD5  = 3'd5,
        W_VECTOR = 3'd6,
        W_MASTER = 3'd7
    } reg_word_e;

    // Bit positions in the master control word.
    localparam int unsigned MCTL_OUT_BIT = 0;
    localparam int unsigned MCTL_CAP_BIT = 1;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

    // R10: the stable stage is always the metastable stage one cycle late
    a_r10_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o == $past(st_q.meta));
endmodule

// File: rtl/irqc_latch.sv
module irqc_latch #(
    parameter int unsigned       N_SRC = 32,
    parameter logic [N_SRC-1:0]  KIND  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] line_i,
    input  logic             cap_en_i,
    input  logic [N_SRC-1:0] ack_i,
    output logic [N_SRC-1:0] status_o
);
    localparam logic [N_SRC-1:0] LEVEL_MASK = ~KIND;

    typedef struct packed {
        logic [N_SRC-1:0] line;
        logic [N_SRC-1:0] status;
    } latch_st_t;

    latch_st_t        st_d, st_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] set_now;

    always_comb begin
        st_d      = st_q;
        rise      = line_i & ~st_q.line;
        set_now   = '0;
        if (cap_en_i) begin
            set_now = (rise & KIND) | (line_i & LEVEL_MASK);
        end
        // clear first, then set: a same-cycle event outlives its acknowledge
        st_d.status = (st_q.status & ~ack_i) | set_now;
        st_d.line   = line_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R2: a high level line with capture on is present one cycle later
    a_r2_level_relatch: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_i |=> (($past(line_i) & LEVEL_MASK & ~st_q.status) == '0));

    // R3: a newly set edge bit needs a rise in the cycle before
    a_r3_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & ~$past(st_q.status) & KIND &
                   ~($past(line_i) & ~$past(st_q.line))) == '0));

    // R4: nothing new is captured while capture is off
    a_r4_no_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> ((st_q.status & ~$past(st_q.status)) == '0));

    // R5: with capture off an acknowledged bit reads clear
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> ((st_q.status & $past(ack_i)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R8: the chosen source is requesting and nothing below it is
    a_r8_idx_requesting: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> req_i[idx_o]);
    a_r8_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((req_i & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0));
    a_r8_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (req_i == '0));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
    parameter int unsigned       N_SRC  = 32,
    parameter int unsigned       DATA_W = 32,
    parameter int unsigned       ADDR_W = 5,
    parameter logic [N_SRC-1:0]  KIND   = N_SRC'(32'h0000_00F0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_o
);
    import irqc_pkg::*;

    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0]  enable;
        logic              out_en;
        logic              cap_en;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctrl_st_t;

    ctrl_st_t          st_d, st_q;
    logic [N_SRC-1:0]  line_sync;
    logic [N_SRC-1:0]  status;
    logic [N_SRC-1:0]  pending;
    logic [N_SRC-1:0]  ack_pulse;
    logic              vec_hit;
    logic [IDX_W-1:0]  vec_idx;
    logic              aligned;
    reg_word_e         word;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] pend_w;
    logic [DATA_W-1:0] enable_w;
    logic [DATA_W-1:0] vector_w;
    logic [DATA_W-1:0] read_mux;

    irqc_sync #(.WIDTH(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (line_sync)
    );

    irqc_latch #(.N_SRC(N_SRC), .KIND(KIND)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_sync),
        .cap_en_i (st_q.cap_en),
        .ack_i    (ack_pulse),
        .status_o (status)
    );

    irqc_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (pending),
        .hit_o (vec_hit),
        .idx_o (vec_idx)
    );

    assign pending = status & st_q.enable;
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = reg_word_e'(bus_addr[4:2]);
    assign wr_en   = bus_sel & bus_we & aligned;
    assign rd_en   = bus_sel & ~bus_we;

    always_comb begin
        ack_pulse = '0;
        if (wr_en && word == W_ACK) begin
            ack_pulse = bus_wdata[N_SRC-1:0];
        end
    end

    always_comb begin
        status_w               = '0;
        status_w[N_SRC-1:0]    = status;
        pend_w                 = '0;
        pend_w[N_SRC-1:0]      = pending;
        enable_w               = '0;
        enable_w[N_SRC-1:0]    = st_q.enable;
        vector_w               = '1;
        if (vec_hit) begin
            vector_w             = '0;
            vector_w[IDX_W-1:0]  = vec_idx;
        end
        read_mux = '0;
        if (aligned) begin
            case (word)
                W_STATUS: read_mux = status_w;
                W_PEND:   read_mux = pend_w;
                W_ENABLE: read_mux = enable_w;
                W_VECTOR: read_mux = vector_w;
                W_MASTER: begin
                    read_mux[MCTL_OUT_BIT] = st_q.out_en;
                    read_mux[MCTL_CAP_BIT] = st_q.cap_en;
                end
                default:  read_mux = '0;
            endcase
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.rdata = read_mux;
        end
        if (wr_en) begin
            case (word)
                W_ENABLE: st_d.enable = bus_wdata[N_SRC-1:0];
                W_MASTER: begin
                    st_d.out_en = bus_wdata[MCTL_OUT_BIT];
                    st_d.cap_en = bus_wdata[MCTL_CAP_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign irq_o      = st_q.out_en & (|pending);

    // R6: a pending bit never lies outside the enable mask
    a_r6_pending_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~st_q.enable) == '0);

    // R7: the output is quiet whenever the vector finds nothing
    a_r7_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_hit);

    // R9: a read of the acknowledge word returns zero next cycle
    a_r9_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && aligned && word == W_ACK) |=> (bus_rvalid && bus_rdata == '0));

    // R10: read data is valid exactly one cycle after a request
    a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);
endmodule

// File: tb/irqc_ctrl_bench.sv
module irqc_ctrl_bench;
    localparam int N = 32;

    localparam logic [4:0] A_STATUS = 5'h00;
    localparam logic [4:0] A_PEND   = 5'h04;
    localparam logic [4:0] A_ENABLE = 5'h08;
    localparam logic [4:0] A_ACK    = 5'h0C;
    localparam logic [4:0] A_VECTOR = 5'h18;
    localparam logic [4:0] A_MASTER = 5'h1C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          irq_o;

    always #4ns clk = ~clk;

    irqc_ctrl #(.N_SRC(N), .DATA_W(32), .ADDR_W(5), .KIND(32'h0000_00F0)) u_irqc_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (pins),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_o      (irq_o)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected read data as the design returns it.
    always @(negedge clk) begin : monitor
        sb_item_t it;
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                check("R10 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    // All tasks start and end just after a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        sb.push_back('{exp: exp, tag: tag});
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin : driver
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq_o after reset", {31'd0, irq_o}, 32'd0);
        rd(A_STATUS, 32'h0, "R1 status reset");
        rd(A_PEND,   32'h0, "R1 pending reset");
        rd(A_ENABLE, 32'h0, "R1 enable reset");
        rd(A_MASTER, 32'h0, "R1 master reset");
        rd(A_VECTOR, 32'hFFFF_FFFF, "R1 vector empty");

        // R4 capture off: level pin0 and edge pin4 rise, nothing latched
        pins[0] = 1'b1; pins[4] = 1'b1;
        idle(5);
        rd(A_STATUS, 32'h0, "R4 no capture while off");

        // R4/R2 capture on: level pin0 latches, old rise on pin4 does not
        wr(A_MASTER, 32'h2);
        idle(4);
        rd(A_STATUS, 32'h1, "R4 R2 level latched, stale edge ignored");
        pins[4] = 1'b0;

        // R2 ack while level held high has no lasting effect
        wr(A_ACK, 32'h1);
        idle(1);
        rd(A_STATUS, 32'h1, "R2 level survives ack");
        pins[0] = 1'b0;
        idle(4);
        wr(A_ACK, 32'h1);
        rd(A_STATUS, 32'h0, "R5 ack clears released level");

        // R3 edge source: latch on rise, stay clear after ack while held
        pins[5] = 1'b1;
        idle(4);
        rd(A_STATUS, 32'h20, "R3 edge latched on rise");
        wr(A_ACK, 32'h20);
        idle(4);
        rd(A_STATUS, 32'h0, "R3 edge stays clear while held");
        pins[5] = 1'b0;

        // R5 ack with zero data leaves status alone
        pins[6] = 1'b1;
        idle(4);
        wr(A_ACK, 32'h0);
        rd(A_STATUS, 32'h40, "R5 zero ack no effect");
        wr(A_ACK, 32'h40);
        pins[6] = 1'b0;
        rd(A_STATUS, 32'h0, "R5 ack one clears edge");

        // R6/R7/R8 pending, output gate and vector
        pins[1] = 1'b1; pins[2] = 1'b1;
        idle(4);
        wr(A_ENABLE, 32'h4);
        rd(A_PEND, 32'h4, "R6 pending = status and enable");
        rd(A_VECTOR, 32'd2, "R8 vector lowest pending 2");
        check("R7 irq_o low without output enable", {31'd0, irq_o}, 32'd0);
        wr(A_MASTER, 32'h3);
        check("R7 irq_o high with pending and enable", {31'd0, irq_o}, 32'd1);
        wr(A_ENABLE, 32'h6);
        rd(A_VECTOR, 32'd1, "R8 vector lowest pending 1");
        wr(A_ENABLE, 32'h0);
        rd(A_VECTOR, 32'hFFFF_FFFF, "R8 vector empty with mask zero");
        check("R7 irq_o low with nothing pending", {31'd0, irq_o}, 32'd0);

        // R9 writes to read-only words ignored, ack reads zero
        wr(A_STATUS, 32'hFFFF_FFFF);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_STATUS, 32'h6, "R9 status write ignored");
        rd(A_PEND, 32'h0, "R9 pending write ignored");
        rd(A_ACK, 32'h0, "R9 ack reads zero");

        // R5 same-cycle rise and ack: the event wins
        pins[1] = 1'b0; pins[2] = 1'b0;
        idle(4);
        wr(A_ACK, 32'h6);
        pins[7] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h80;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(A_STATUS, 32'h80, "R5 event wins over same-cycle ack");
        wr(A_ACK, 32'h80);
        pins[7] = 1'b0;

        // R10 latency: rise shows on irq_o after the third edge
        wr(A_ENABLE, 32'h8);
        idle(2);
        pins[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 irq_o low after edge 1", {31'd0, irq_o}, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10 irq_o low after edge 2", {31'd0, irq_o}, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10 irq_o high after edge 3", {31'd0, irq_o}, 32'd1);

        idle(3);
        check("R10 scoreboard drained", sb.size(), 32'd0);
        finish_run();
    end
endmodule